// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit sits beside an instruction sequencer. It takes the second word of a two-word instruction (the operand) together with the addressing mode and access kind decoded from the opcode. It also takes the current instruction pointer, the index register and the two data registers. From these it works out what the instruction needs. For an immediate or register-reference load, that is a data value. For a load or store through memory, it is a 16-bit effective memory address together with a read or a write request. For a jump, it is the new instruction pointer value. Memory, the ALU and the register file itself lie outside the block.

All address arithmetic wraps modulo 2^16. An operand such as FFF0 therefore acts as a negative displacement in relative and indexed modes, with no separate sign path. The instruction pointer used for relative mode is the value the sequencer holds once both instruction words are fetched. A parameter adds a fixed bias to it, and that bias is zero here. Combinations that cannot be executed raise an error flag in place of any memory or pointer action. A store with an immediate operand is one such combination.

A request is accepted on any clock with `req_valid` high. Its result appears on the registered outputs on the next clock.

Top module: `oeag_top`

## Requirements
- R1: While `rst_n` is low, and after reset until the first request, every output is zero.
- R2: Each result is registered. `res_valid` is high exactly in the cycle after a cycle with `req_valid` high. In a cycle after `req_valid` low, all outputs are zero.
- R3: Immediate load (kind 0, mode 0): `res_data` equals the operand, and no read, write or pointer load is raised.
- R4: Direct mode (mode 1): `res_addr` equals the operand. A load (kind 0) raises `res_mem_rd` and a store (kind 1) raises `res_mem_wr`.
- R5: Indexed mode (mode 3): `res_addr` equals operand plus index modulo 2^16 (0801 with index 0002 gives 0803). Read or write follows the kind as in R4.
- R6: Relative jump (kind 2, mode 2): `res_ip_load` is high and `res_ip_next` equals pointer plus operand modulo 2^16 (0300+0009=0309, 0510+FFF0=0500, and FFFA moves the pointer back by six).
- R7: A direct jump loads the operand into `res_ip_next`. An indexed jump loads operand plus index. Both raise `res_ip_load`.
- R8: Register-reference load (kind 0, mode 4): `res_data` is the accumulator when `req_reg_sel` is 0 and register B when it is 1. No memory access is requested.
- R9: The following raise `res_err`, with read, write and pointer load all low and `res_addr`, `res_data` and `res_ip_next` zero: a store in immediate, relative or register-reference mode; a load in relative mode; a jump in immediate or register-reference mode; kind 3; and mode codes 5 to 7.
- R10: At most one of `res_mem_rd`, `res_mem_wr` and `res_ip_load` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 jump, 3 reserved |
| req_mode | input | 3 | Addressing mode: 0 immediate, 1 direct, 2 relative, 3 indexed, 4 register-reference |
| req_reg_sel | input | 1 | Register-reference source: 0 accumulator, 1 register B |
| req_operand | input | 16 | Operand word of the instruction |
| req_ip | input | 16 | Instruction pointer after both words are fetched |
| req_index | input | 16 | Index register |
| req_acc | input | 16 | Accumulator |
| req_regb | input | 16 | Register B |
| res_valid | output | 1 | Result present |
| res_err | output | 1 | Illegal combination |
| res_mem_rd | output | 1 | Memory data read needed at `res_addr` |
| res_mem_wr | output | 1 | Memory data write needed at `res_addr` |
| res_ip_load | output | 1 | Load `res_ip_next` into the pointer |
| res_addr | output | 16 | Effective memory address |
| res_data | output | 16 | Immediate or register data |
| res_ip_next | output | 16 | Jump target |

## Verification
Every result is due exactly one clock after the request is taken. The bench drives each request on a falling edge and lets one rising edge pass. It then samples all outputs on the next falling edge and compares them with values its own functions compute. Idle cycles are checked the same way, one edge after `req_valid` drops. This shows that nothing lingers from the previous request. The reset state is sampled both while reset is held and before the first request.

// File: rtl/oeag_pkg.sv
package oeag_pkg;
  localparam int WORD_W = 16;
  localparam int MODE_W = 3;
  localparam int KIND_W = 2;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [MODE_W-1:0] {
    AM_IMM = 3'd0,
    AM_DIR = 3'd1,
    AM_REL = 3'd2,
    AM_IDX = 3'd3,
    AM_REG = 3'd4
  } amode_e;

  typedef enum logic [KIND_W-1:0] {
    AK_LOAD  = 2'd0,
    AK_STORE = 2'd1,
    AK_JUMP  = 2'd2,
    AK_RSVD  = 2'd3
  } akind_e;

  // Modulo-2^WORD_W sum: a negative displacement is just a large operand.
  function automatic word_t wrap_add(input word_t a, input word_t b);
    logic [WORD_W:0] full;
    full = {1'b0, a} + {1'b0, b};
    return full[WORD_W-1:0];
  endfunction

  function automatic word_t pick_reg(input logic sel, input word_t acc, input word_t regb);
    return sel ? regb : acc;
  endfunction
endpackage

// File: rtl/oeag_calc.sv
module oeag_calc
  import oeag_pkg::*;
#(
  parameter word_t IP_BIAS = '0
) (
  input  logic [MODE_W-1:0] mode,
  input  logic              reg_sel,
  input  word_t             operand,
  input  word_t             ip,
  input  word_t             index,
  input  word_t             acc,
  input  word_t             regb,
  output word_t             mem_ea,
  output word_t             rel_target,
  output word_t             reg_data
);
  word_t ip_base;
  word_t idx_sum;

  assign ip_base    = wrap_add(ip, IP_BIAS);
  assign idx_sum    = wrap_add(operand, index);
  assign rel_target = wrap_add(ip_base, operand);
  assign reg_data   = pick_reg(reg_sel, acc, regb);

  always_comb begin
    mem_ea = operand;
    if (mode == AM_IDX) mem_ea = idx_sum;
  end

  always_comb begin
    assert ((mode != AM_DIR) || (mem_ea == operand))
      else $error("assert_direct_ea_R4");
  end
endmodule

// File: rtl/oeag_rules.sv
module oeag_rules
  import oeag_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  input  logic [MODE_W-1:0] mode,
  output logic              legal,
  output logic              want_rd,
  output logic              want_wr,
  output logic              want_jump,
  output logic              want_data
);
  logic is_mem_mode;
  logic is_val_mode;

  assign is_mem_mode = (mode == AM_DIR) || (mode == AM_IDX);
  assign is_val_mode = (mode == AM_IMM) || (mode == AM_REG);

  always_comb begin
    want_rd   = 1'b0;
    want_wr   = 1'b0;
    want_jump = 1'b0;
    want_data = 1'b0;
    unique case (kind)
      AK_LOAD: begin
        want_rd   = is_mem_mode;
        want_data = is_val_mode;
      end
      AK_STORE: want_wr   = is_mem_mode;
      AK_JUMP:  want_jump = is_mem_mode || (mode == AM_REL);
      default:  ;
    endcase
    legal = want_rd || want_wr || want_jump || want_data;
  end

  always_comb begin
    assert ($onehot0({want_rd, want_wr, want_jump, want_data}))
      else $error("assert_single_action_R10");
  end
endmodule

// File: rtl/oeag_top.sv
module oeag_top
  import oeag_pkg::*;
#(
  parameter word_t IP_BIAS = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [KIND_W-1:0]      req_kind,
  input  logic [MODE_W-1:0]      req_mode,
  input  logic                   req_reg_sel,
  input  logic [WORD_W-1:0]      req_operand,
  input  logic [WORD_W-1:0]      req_ip,
  input  logic [WORD_W-1:0]      req_index,
  input  logic [WORD_W-1:0]      req_acc,
  input  logic [WORD_W-1:0]      req_regb,
  output logic                   res_valid,
  output logic                   res_err,
  output logic                   res_mem_rd,
  output logic                   res_mem_wr,
  output logic                   res_ip_load,
  output logic [WORD_W-1:0]      res_addr,
  output logic [WORD_W-1:0]      res_data,
  output logic [WORD_W-1:0]      res_ip_next
);
  word_t mem_ea, rel_target, reg_data;
  logic  legal, want_rd, want_wr, want_jump, want_data;

  oeag_calc #(.IP_BIAS(IP_BIAS)) calc_i (
    .mode       (req_mode),
    .reg_sel    (req_reg_sel),
    .operand    (req_operand),
    .ip         (req_ip),
    .index      (req_index),
    .acc        (req_acc),
    .regb       (req_regb),
    .mem_ea     (mem_ea),
    .rel_target (rel_target),
    .reg_data   (reg_data)
  );

  oeag_rules rules_i (
    .kind      (req_kind),
    .mode      (req_mode),
    .legal     (legal),
    .want_rd   (want_rd),
    .want_wr   (want_wr),
    .want_jump (want_jump),
    .want_data (want_data)
  );

  // Named next-state events for the assertions.
  logic  nx_err, nx_rd, nx_wr, nx_jump;
  word_t nx_addr, nx_data, nx_ip;

  always_comb begin
    nx_err  = req_valid && !legal;
    nx_rd   = req_valid && want_rd;
    nx_wr   = req_valid && want_wr;
    nx_jump = req_valid && want_jump;
    nx_addr = (nx_rd || nx_wr) ? mem_ea : '0;
    nx_data = '0;
    if (req_valid && want_data)
      nx_data = (req_mode == AM_REG) ? reg_data : req_operand;
    nx_ip = '0;
    if (nx_jump)
      nx_ip = (req_mode == AM_REL) ? rel_target : mem_ea;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_err     <= 1'b0;
      res_mem_rd  <= 1'b0;
      res_mem_wr  <= 1'b0;
      res_ip_load <= 1'b0;
      res_addr    <= '0;
      res_data    <= '0;
      res_ip_next <= '0;
    end else begin
      res_valid   <= req_valid;
      res_err     <= nx_err;
      res_mem_rd  <= nx_rd;
      res_mem_wr  <= nx_wr;
      res_ip_load <= nx_jump;
      res_addr    <= nx_addr;
      res_data    <= nx_data;
      res_ip_next <= nx_ip;
    end
  end

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid && !res_err && res_addr == '0 && res_data == '0);
  assert_imm_no_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == AM_IMM) |=> !res_mem_rd && !res_mem_wr && !res_ip_load);
  assert_rel_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == AK_JUMP && req_mode == AM_REL) |=>
      res_ip_load && res_ip_next == wrap_add(wrap_add($past(req_ip), IP_BIAS), $past(req_operand)));
  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_err |-> !res_mem_rd && !res_mem_wr && !res_ip_load && res_valid);
  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_mem_rd, res_mem_wr, res_ip_load}));
endmodule

// File: tb/oeag_top_tb_top.sv
module oeag_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [2:0]  req_mode = '0;
  logic        req_reg_sel = 1'b0;
  logic [15:0] req_operand = '0, req_ip = '0, req_index = '0, req_acc = '0, req_regb = '0;
  logic        res_valid, res_err, res_mem_rd, res_mem_wr, res_ip_load;
  logic [15:0] res_addr, res_data, res_ip_next;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  oeag_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_mode(req_mode), .req_reg_sel(req_reg_sel), .req_operand(req_operand),
    .req_ip(req_ip), .req_index(req_index), .req_acc(req_acc), .req_regb(req_regb),
    .res_valid(res_valid), .res_err(res_err), .res_mem_rd(res_mem_rd),
    .res_mem_wr(res_mem_wr), .res_ip_load(res_ip_load), .res_addr(res_addr),
    .res_data(res_data), .res_ip_next(res_ip_next)
  );

  // Packed view: {valid, err, rd, wr, jump, addr, data, ip_next}
  function automatic logic [52:0] actual();
    return {res_valid, res_err, res_mem_rd, res_mem_wr, res_ip_load, res_addr, res_data, res_ip_next};
  endfunction

  function automatic logic [52:0] model(input logic v, input logic [1:0] k, input logic [2:0] m,
      input logic s, input logic [15:0] op, ip, ix, a, b);
    logic err, rd, wr, jp;
    logic [15:0] ad, dt, nx;
    err = 0; rd = 0; wr = 0; jp = 0; ad = 0; dt = 0; nx = 0;
    if (v) begin
      if (k == 0 && m == 0) dt = op;
      else if (k == 0 && m == 4) dt = s ? b : a;
      else if (k < 2 && (m == 1 || m == 3)) begin
        ad = (m == 3) ? 16'(op + ix) : op;
        rd = (k == 0); wr = (k == 1);
      end else if (k == 2 && m >= 1 && m <= 3) begin
        jp = 1;
        nx = (m == 1) ? op : (m == 2) ? 16'(ip + op) : 16'(op + ix);
      end else err = 1;
    end
    return {v, err, rd, wr, jp, ad, dt, nx};
  endfunction

  function automatic string tag_of(input logic v, input logic [1:0] k, input logic [2:0] m);
    if (!v) return "R2";
    if (k == 3 || m > 4) return "R9";
    if (k == 2) return (m == 2) ? "R6" : (m == 1 || m == 3) ? "R7" : "R9";
    if (m == 0) return (k == 0) ? "R3" : "R9";
    if (m == 1) return "R4";
    if (m == 3) return "R5";
    if (m == 4) return (k == 0) ? "R8" : "R9";
    return "R9";
  endfunction

  task automatic check(input string tag, input logic [52:0] exp);
    logic [52:0] act;
    act = actual();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
    if ($countones(act[50:48]) > 1) begin
      errors++;
      $display("FAIL R10: actual strobes=%b expected at most one", act[50:48]);
    end
  endtask

  task automatic run(input logic v, input logic [1:0] k, input logic [2:0] m, input logic s,
      input logic [15:0] op, ip, ix, a, b);
    req_valid = v; req_kind = k; req_mode = m; req_reg_sel = s;
    req_operand = op; req_ip = ip; req_index = ix; req_acc = a; req_regb = b;
    @(posedge clk);
    @(negedge clk);
    check(tag_of(v, k, m), model(v, k, m, s, op, ip, ix, a, b));
  endtask

  function automatic logic [15:0] pick_word(input int unsigned r);
    case (r % 5)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h8000;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1", 53'd0);                 // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 53'd0);                 // R1 after reset, no request yet

    // Directed corner cases
    run(1, 0, 3, 0, 16'h0801, 16'h0000, 16'h0002, 0, 0);        // R5: 0803
    run(1, 1, 3, 0, 16'h0804, 16'h0000, 16'h0002, 0, 0);        // R5 store: 0806
    run(1, 2, 2, 0, 16'h0009, 16'h0300, 0, 0, 0);               // R6: 0309
    run(1, 2, 2, 0, 16'hFFF0, 16'h0510, 0, 0, 0);               // R6: 0500
    run(1, 2, 2, 0, 16'hFFFA, 16'h0420, 0, 0, 0);               // R6: back six
    run(1, 0, 0, 0, 16'h0500, 0, 0, 0, 0);                      // R3
    run(1, 0, 1, 0, 16'h0500, 0, 0, 0, 0);                      // R4 load
    run(1, 1, 1, 0, 16'h0180, 0, 0, 0, 0);                      // R4 store
    run(1, 2, 1, 0, 16'h0A00, 16'h1234, 0, 0, 0);               // R7 direct
    run(1, 2, 3, 0, 16'hFFFF, 16'h1234, 16'h0003, 0, 0);        // R7 indexed wrap
    run(1, 0, 4, 0, 0, 0, 0, 16'h1039, 16'h0005);               // R8 acc
    run(1, 0, 4, 1, 0, 0, 0, 16'h1039, 16'h0005);               // R8 regb
    run(1, 1, 0, 0, 16'h0300, 0, 0, 0, 0);                      // R9 store immediate
    run(1, 0, 2, 0, 16'h0010, 16'h0100, 0, 0, 0);               // R9 load relative
    run(1, 2, 4, 0, 0, 0, 0, 16'h1, 16'h2);                     // R9 jump register
    run(1, 3, 1, 0, 16'h0100, 0, 0, 0, 0);                      // R9 reserved kind
    run(1, 0, 6, 0, 16'h0100, 0, 0, 0, 0);                      // R9 bad mode
    run(0, 0, 1, 0, 16'h0100, 0, 0, 0, 0);                      // R2 idle clears

    // Constrained random mix
    for (int i = 0; i < 600; i++) begin
      int unsigned r;
      r = $urandom;
      run((r % 8) != 0, 2'($urandom), 3'($urandom % 8), 1'($urandom),
          pick_word($urandom), pick_word($urandom), pick_word($urandom),
          16'($urandom), 16'($urandom));
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule